// File: doc/BRIEF.md
# One-Wire Bus Master Controller

This block is the sole master on a single open-drain serial line that carries both data and timing to one or more slave devices. An external resistor pulls the line high. The block can only pull the line low or let it go, and it never drives it high. All timing is measured in whole microseconds. A divider turns the system clock into a microsecond tick, and a timer counts those ticks. Holding the line low for a long time resets every slave on the bus. Short low pulses inside fixed-length bit slots carry the data bits.

The user side is a single-cycle command port with three operations. The first issues a bus reset and reports whether any slave answered with a presence pulse. The second writes one byte. The third reads one byte. Both byte operations move the least significant bit first. `busy` is high while an operation runs. `done` pulses for one cycle as `busy` falls. Between commands, and between bit slots, the line is left released. This means the user can wait any length of time between operations without disturbing the bus.

Top module: `owm_master`

## Requirements
- R1: While `rstN` is low, and after it is released, `busLow` is 0, `busy` and `done` are 0, `presence` is 0 and `rdData` is 0.
- R2: A reset command (`cmdOp` = 2'b01) pulls the line low for at least RESET_LOW_US (480 µs) and at most 482 µs, then releases it. The operation ends no earlier than RESET_WIN_US (480 µs) after the release.
- R3: The line is sampled PRES_SAMPLE_US (70 µs) after the reset release. `presence` becomes 1 if the line was low and 0 if it was high. `presence` changes only in the cycle `done` is high, and it keeps its previous value until then.
- R4: A write command (`cmdOp` = 2'b10) sends `cmdData` as 8 bit slots, least significant bit first.
- R5: In a write slot, a 1 bit is a low pulse of SHORT_LOW_US (6 µs) and a 0 bit is a low pulse of LONG_LOW_US (60 µs). Every slot lasts SLOT_US (70 µs) and is followed by at least 1 µs of released line before the next low pulse.
- R6: A read command (`cmdOp` = 2'b11) issues 8 slots. Each slot pulls low for 6 µs, then samples the line RD_SAMPLE_US (15 µs) after the slot start. The sampled bits are assembled least significant bit first. `rdData` changes only in the `done` cycle of a read, so writes and resets leave it unchanged.
- R7: The block only ever pulls low (`busLow` = 1) or releases the line, and `busLow` is 0 whenever `busy` is 0.
- R8: A command is taken only when `cmdValid` is 1, `busy` is 0 and `cmdOp` is not 2'b00. Commands offered while busy, and the 2'b00 opcode, have no effect.
- R9: `done` is high for exactly one cycle, the first cycle with `busy` low. A command offered in that same cycle is accepted, so `busy` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 2 | 00 none, 01 bus reset, 10 write byte, 11 read byte |
| cmdData | input | 8 | Byte to write |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | A slave answered the last bus reset |
| rdData | output | 8 | Byte from the last read |
| busLow | output | 1 | Open-drain enable: 1 pulls the line low, 0 releases it |
| lineIn | input | 1 | Sensed line level |

## Verification
Two things can fall in the same cycle: an operation completing and a new command arriving. The bench raises `cmdValid` with a read in the exact cycle where `done` is seen high after a write. It then requires `busy` to be high and `done` to be low one cycle later, and requires the read to return the byte the slave model supplies. A second collision is also provoked: a read command is offered in the middle of a write. For this case the bench requires that the written byte arrives intact, that no extra operation starts afterwards, and that `rdData` keeps its old value.

// File: rtl/owm_pkg.sv
package owm_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_RESET = 2'b01,
    OP_WRITE = 2'b10,
    OP_READ  = 2'b11
  } owOp_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic clrTimer;  // restart microsecond timer and divider
    logic load;      // load shift register, clear bit count
    logic shift;     // shift register right, line bit in at top
    logic bitAdv;    // one slot finished
    logic capPres;   // capture presence sample
    logic pubPres;   // publish presence flag
    logic pubRead;   // publish read byte
  } owStrobe_t;

endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
  parameter int CYC_PER_US = 250
) (
  input  logic clk,
  input  logic rstN,
  input  logic clear,
  output logic usTick
);
  generate
    if (CYC_PER_US <= 1) begin : g_direct
      assign usTick = 1'b1;
    end else begin : g_div
      localparam int DW = $clog2(CYC_PER_US);
      localparam logic [DW-1:0] LAST = DW'(CYC_PER_US - 1);
      logic [DW-1:0] divCnt;
      assign usTick = (divCnt == LAST);
      always_ff @(posedge clk) begin
        if (!rstN || clear || usTick) divCnt <= '0;
        else                          divCnt <= divCnt + 1'b1;
      end
    end
  endgenerate
endmodule

// File: rtl/owm_datapath.sv
module owm_datapath
  import owm_pkg::*;
#(
  parameter int CYC_PER_US  = 250,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  owStrobe_t         strobe,
  input  logic [DATA_W-1:0] cmdData,
  input  logic              lineIn,
  output logic [CNT_W-1:0]  usCount,
  output logic              txBit,
  output logic              lastBit,
  output logic              presence,
  output logic [DATA_W-1:0] rdData
);
  localparam int BC_W = $clog2(DATA_W + 1);
  localparam logic [BC_W-1:0] BIT_END = BC_W'(DATA_W);

  logic usTick;
  logic lineS;
  logic [DATA_W-1:0] shReg;
  logic [BC_W-1:0] bitCnt;
  logic presSample;

  owm_tick #(.CYC_PER_US(CYC_PER_US)) uTick (
    .clk(clk), .rstN(rstN), .clear(strobe.clrTimer), .usTick(usTick)
  );

  // line synchroniser, resets to the released level
  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic syncQ;
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= 1'b1;
        else       syncQ <= lineIn;
      end
      assign lineS = syncQ;
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] syncQ;
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
      end
      assign lineS = syncQ[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrTimer) usCount <= '0;
    else if (usTick && usCount != '1) usCount <= usCount + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '0;
      bitCnt <= '0;
    end else begin
      if (strobe.load)       shReg <= cmdData;
      else if (strobe.shift) shReg <= {lineS, shReg[DATA_W-1:1]};
      if (strobe.load)         bitCnt <= '0;
      else if (strobe.bitAdv)  bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      presSample <= 1'b0;
      presence   <= 1'b0;
      rdData     <= '0;
    end else begin
      if (strobe.capPres) presSample <= ~lineS;
      if (strobe.pubPres) presence   <= presSample;
      if (strobe.pubRead) rdData     <= shReg;
    end
  end

  assign txBit   = shReg[0];
  assign lastBit = (bitCnt == BIT_END);
endmodule

// File: rtl/owm_ctrl.sv
module owm_ctrl
  import owm_pkg::*;
#(
  parameter int CNT_W          = 9,
  parameter int RESET_LOW_US   = 480,
  parameter int PRES_SAMPLE_US = 70,
  parameter int RESET_WIN_US   = 480,
  parameter int SHORT_LOW_US   = 6,
  parameter int LONG_LOW_US    = 60,
  parameter int RD_SAMPLE_US   = 15,
  parameter int SLOT_US        = 70,
  parameter int REC_US         = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [1:0]       cmdOp,
  input  logic [CNT_W-1:0] usCount,
  input  logic             txBit,
  input  logic             lastBit,
  output owStrobe_t        strobe,
  output logic             busy,
  output logic             done,
  output logic             busLow
);
  localparam logic [CNT_W-1:0] T_RLOW  = CNT_W'(RESET_LOW_US);
  localparam logic [CNT_W-1:0] T_PRES  = CNT_W'(PRES_SAMPLE_US);
  localparam logic [CNT_W-1:0] T_RWIN  = CNT_W'(RESET_WIN_US);
  localparam logic [CNT_W-1:0] T_SHORT = CNT_W'(SHORT_LOW_US);
  localparam logic [CNT_W-1:0] T_LONG  = CNT_W'(LONG_LOW_US);
  localparam logic [CNT_W-1:0] T_SAMP  = CNT_W'(RD_SAMPLE_US);
  localparam logic [CNT_W-1:0] T_SLOT  = CNT_W'(SLOT_US);
  localparam logic [CNT_W-1:0] T_REC   = CNT_W'(REC_US);

  typedef enum logic [2:0] {
    S_IDLE, S_RST_LOW, S_RST_SENSE, S_RST_REST,
    S_SLOT_LOW, S_SLOT_SAMPLE, S_SLOT_REST, S_SLOT_REC
  } owState_e;

  owState_e state, nextState;
  logic isRead, nextIsRead, finish;
  logic [CNT_W-1:0] lowLen;
  owOp_e op;

  assign op     = owOp_e'(cmdOp);
  assign lowLen = (isRead || txBit) ? T_SHORT : T_LONG;

  always_comb begin
    nextState  = state;
    nextIsRead = isRead;
    strobe     = '0;
    finish     = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (cmdValid && op == OP_RESET) begin
          strobe.clrTimer = 1'b1;
          nextState       = S_RST_LOW;
        end else if (cmdValid && (op == OP_WRITE || op == OP_READ)) begin
          strobe.clrTimer = 1'b1;
          strobe.load     = 1'b1;
          nextIsRead      = (op == OP_READ);
          nextState       = S_SLOT_LOW;
        end
      end
      S_RST_LOW: if (usCount == T_RLOW) begin
        strobe.clrTimer = 1'b1;
        nextState       = S_RST_SENSE;
      end
      S_RST_SENSE: if (usCount == T_PRES) begin
        strobe.capPres = 1'b1;
        nextState      = S_RST_REST;
      end
      S_RST_REST: if (usCount == T_RWIN) begin
        strobe.pubPres = 1'b1;
        finish         = 1'b1;
        nextState      = S_IDLE;
      end
      S_SLOT_LOW: if (usCount == lowLen) begin
        nextState = isRead ? S_SLOT_SAMPLE : S_SLOT_REST;
      end
      S_SLOT_SAMPLE: if (usCount == T_SAMP) begin
        strobe.shift = 1'b1;
        nextState    = S_SLOT_REST;
      end
      S_SLOT_REST: if (usCount == T_SLOT) begin
        strobe.clrTimer = 1'b1;
        strobe.bitAdv   = 1'b1;
        strobe.shift    = !isRead;
        nextState       = S_SLOT_REC;
      end
      S_SLOT_REC: if (usCount == T_REC) begin
        if (lastBit) begin
          strobe.pubRead = isRead;
          finish         = 1'b1;
          nextState      = S_IDLE;
        end else begin
          strobe.clrTimer = 1'b1;
          nextState       = S_SLOT_LOW;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      isRead <= 1'b0;
      done   <= 1'b0;
      busLow <= 1'b0;
    end else begin
      state  <= nextState;
      isRead <= nextIsRead;
      done   <= finish;
      busLow <= (nextState == S_RST_LOW) || (nextState == S_SLOT_LOW);
    end
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/owm_master.sv
module owm_master
  import owm_pkg::*;
#(
  parameter int CYC_PER_US     = 250,
  parameter int DATA_W         = 8,
  parameter int SYNC_STAGES    = 2,
  parameter int RESET_LOW_US   = 480,
  parameter int PRES_SAMPLE_US = 70,
  parameter int RESET_WIN_US   = 480,
  parameter int SHORT_LOW_US   = 6,
  parameter int LONG_LOW_US    = 60,
  parameter int RD_SAMPLE_US   = 15,
  parameter int SLOT_US        = 70,
  parameter int REC_US         = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [DATA_W-1:0] cmdData,
  output logic              busy,
  output logic              done,
  output logic              presence,
  output logic [DATA_W-1:0] rdData,
  output logic              busLow,
  input  logic              lineIn
);
  localparam int MAX_A  = (RESET_LOW_US > RESET_WIN_US) ? RESET_LOW_US : RESET_WIN_US;
  localparam int MAX_US = (MAX_A > SLOT_US) ? MAX_A : SLOT_US;
  localparam int CNT_W  = $clog2(MAX_US + 2);

  owStrobe_t strobe;
  logic [CNT_W-1:0] usCount;
  logic txBit, lastBit;

  owm_ctrl #(
    .CNT_W(CNT_W), .RESET_LOW_US(RESET_LOW_US), .PRES_SAMPLE_US(PRES_SAMPLE_US),
    .RESET_WIN_US(RESET_WIN_US), .SHORT_LOW_US(SHORT_LOW_US),
    .LONG_LOW_US(LONG_LOW_US), .RD_SAMPLE_US(RD_SAMPLE_US),
    .SLOT_US(SLOT_US), .REC_US(REC_US)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .usCount(usCount), .txBit(txBit), .lastBit(lastBit),
    .strobe(strobe), .busy(busy), .done(done), .busLow(busLow)
  );

  owm_datapath #(
    .CYC_PER_US(CYC_PER_US), .DATA_W(DATA_W),
    .SYNC_STAGES(SYNC_STAGES), .CNT_W(CNT_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdData(cmdData),
    .lineIn(lineIn), .usCount(usCount), .txBit(txBit), .lastBit(lastBit),
    .presence(presence), .rdData(rdData)
  );
endmodule

// File: rtl/owm_checker.sv
module owm_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic [1:0]        cmdOp,
  input logic              busy,
  input logic              done,
  input logic              busLow,
  input logic              presence,
  input logic [DATA_W-1:0] rdData
);
  a_r7_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !busLow);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r9_done_at_fall: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy || $past(busy)));

  a_r8_start_needs_cmd: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(cmdValid) && $past(cmdOp) != 2'b00));

  a_r6_rddata_on_done: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(rdData) |-> done);

  a_r3_presence_on_done: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(presence) |-> done);
endmodule

bind owm_master owm_checker #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
  .busy(busy), .done(done), .busLow(busLow), .presence(presence),
  .rdData(rdData)
);

// File: tb/tb_owm_master.sv
module tb_owm_master;
  localparam int D = 2;  // clocks per microsecond in this configuration

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = 2'b00;
  logic [7:0] cmdData = 8'h00;
  logic busy, done, presence, busLow, lineIn;
  logic [7:0] rdData;
  logic slaveLow = 1'b0;

  always #2 clk = ~clk;  // 250 MHz
  assign lineIn = ~(busLow | slaveLow);

  owm_master #(.CYC_PER_US(D)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .busy(busy), .done(done), .presence(presence),
    .rdData(rdData), .busLow(busLow), .lineIn(lineIn)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- slave model (negedge, race free) ----------------
  bit slaveOn = 1'b1;
  bit txMode = 1'b0;
  logic [7:0] txByte = 8'h00;
  logic [7:0] rxByte = 8'h00;
  int txIdx = 0;
  int lowRun = 0, highRun = 0, lastResetLow = 0;
  int presWait = 0, presHold = 0, rdHold = 0;
  int min1 = 1000000, max1 = 0, min0 = 1000000, max0 = 0, minGap = 1000000;
  int idleLowViol = 0;
  bit prevLow = 1'b0;

  always @(negedge clk) begin
    if (rdHold > 0) rdHold--;
    if (presHold > 0) presHold--;
    if (presWait > 0) begin
      presWait--;
      if (presWait == 0) presHold = 120 * D;
    end
    if (rstN && !busy && busLow) idleLowViol++;
    if (busLow) begin
      if (!prevLow) begin
        if (highRun < 400 * D) minGap = (highRun < minGap) ? highRun : minGap;
        highRun = 0;
        if (txMode) begin
          if (!txByte[txIdx]) rdHold = 30 * D;
          txIdx = (txIdx + 1) % 8;
        end
      end
      lowRun++;
    end else begin
      if (prevLow) begin
        if (lowRun >= 400 * D) begin
          lastResetLow = lowRun;
          if (slaveOn) presWait = 30 * D;
        end else if (!txMode) begin
          rxByte = {(lowRun < 15 * D), rxByte[7:1]};
          if (lowRun < 15 * D) begin
            min1 = (lowRun < min1) ? lowRun : min1;
            max1 = (lowRun > max1) ? lowRun : max1;
          end else begin
            min0 = (lowRun < min0) ? lowRun : min0;
            max0 = (lowRun > max0) ? lowRun : max0;
          end
        end
        lowRun = 0;
      end
      highRun++;
    end
    prevLow  = busLow;
    slaveLow = (rdHold > 0) || (presHold > 0);
  end

  // ---------------- driver tasks ----------------
  int opCycles = 0;

  task automatic issue(input logic [1:0] op, input logic [7:0] data);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'b00;
  endtask

  task automatic waitDone();
    opCycles = 1;
    while (!done) begin
      @(negedge clk);
      opCycles++;
    end
  endtask

  task automatic runOp(input logic [1:0] op, input logic [7:0] data);
    issue(op, data);
    waitDone();
  endtask

  function automatic logic [7:0] pattern(input int i);
    if (i == 0) return 8'h00;
    if (i == 1) return 8'hFF;
    if (i == 2) return 8'h01;
    if (i == 3) return 8'h80;
    return 8'((i * 97 + 13) & 255);
  endfunction

  initial begin
    logic [7:0] lastRead;
    logic [7:0] v;
    repeat (5) @(negedge clk);
    // R1: state under and after reset
    check(busLow == 0 && busy == 0 && done == 0, "R1 idle outputs in reset", {busLow, busy, done}, 0);
    check(presence == 0 && rdData == 0, "R1 flags in reset", {presence, rdData}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(busLow == 0 && busy == 0 && presence == 0 && rdData == 0, "R1 after reset release",
          {busLow, busy, presence, rdData}, 0);

    // R2/R3: reset with slave present
    slaveOn = 1'b1;
    runOp(2'b01, 8'h00);
    check(lastResetLow >= 480 * D && lastResetLow <= 482 * D, "R2 reset low length", lastResetLow, 480 * D);
    check(opCycles >= 960 * D, "R2 reset window", opCycles, 960 * D);
    check(presence == 1, "R3 presence with slave", presence, 1);

    // R3: no slave; flag holds old value until done
    slaveOn = 1'b0;
    issue(2'b01, 8'h00);
    repeat (680 * D) @(negedge clk);
    check(busy == 1 && presence == 1, "R3 presence held until done", {busy, presence}, 3);
    waitDone();
    check(presence == 0, "R3 no presence", presence, 0);
    slaveOn = 1'b1;
    runOp(2'b01, 8'h00);
    check(presence == 1, "R3 presence again", presence, 1);

    // R4/R5/R6: write sweep
    txMode = 1'b0;
    lastRead = rdData;
    for (int i = 0; i < 32; i++) begin
      v = pattern(i);
      runOp(2'b10, v);
      check(rxByte == v, "R4 written byte lsb first", rxByte, v);
      check(rdData == lastRead, "R6 write keeps rdData", rdData, lastRead);
    end
    check(min1 >= 6 * D && max1 <= 6 * D + 2, "R5 write-1 low length", max1, 6 * D);
    check(min0 >= 60 * D && max0 <= 60 * D + 2, "R5 write-0 low length", max0, 60 * D);
    check(minGap >= 1 * D, "R5 recovery between slots", minGap, D);

    // R6: read sweep
    txMode = 1'b1;
    for (int i = 0; i < 32; i++) begin
      v = pattern(i + 5);
      txByte = v;
      runOp(2'b11, 8'h00);
      check(rdData == v, "R6 read byte lsb first", rdData, v);
    end
    lastRead = rdData;

    // R8: command while busy is ignored
    txMode = 1'b0;
    issue(2'b10, 8'hA5);
    repeat (100) @(negedge clk);
    cmdValid = 1'b1; cmdOp = 2'b11;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'b00;
    waitDone();
    repeat (20) @(negedge clk);
    check(busy == 0, "R8 no extra op after busy command", busy, 0);
    check(rxByte == 8'hA5, "R8 write intact", rxByte, 8'hA5);
    check(rdData == lastRead, "R8 rdData untouched", rdData, lastRead);
    cmdValid = 1'b1; cmdOp = 2'b00;
    @(negedge clk);
    cmdValid = 1'b0;
    @(negedge clk);
    check(busy == 0 && busLow == 0, "R8 opcode none ignored", {busy, busLow}, 0);

    // R9: new command in the done cycle
    issue(2'b10, 8'h3C);
    waitDone();
    txMode = 1'b1; txByte = 8'hC6;
    cmdValid = 1'b1; cmdOp = 2'b11;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = 2'b00;
    check(busy == 1, "R9 command in done cycle accepted", busy, 1);
    check(done == 0, "R9 done single cycle", done, 0);
    check(rxByte == 8'h3C, "R9 prior write intact", rxByte, 8'h3C);
    waitDone();
    check(rdData == 8'hC6, "R9 back-to-back read", rdData, 8'hC6);

    repeat (10) @(negedge clk);
    check(idleLowViol == 0, "R7 line released while idle", idleLowViol, 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule